// File: doc/BRIEF.md
# Framed Serial DAC Register Interface

This block is the digital front end of a single-channel voltage-output DAC. A host writes it over a three-wire serial link made of an active-low frame select (`fsync_n`), a serial clock (`sclk`) and a data line (`sdin`). The block runs on its own system clock. It resynchronises the three pins and detects the edges it needs. It shifts in one 24-bit frame per selection and commits the result to two registers: a 16-bit output code and a 2-bit output-termination mode. The analog stage reads both registers.

A frame is committed on its final serial clock fall, so `fsync_n` does not have to rise first. If `fsync_n` rises before that fall, the frame is abandoned and leaves no trace. A frame that selects a power-down mode changes only the mode register. The stored code is kept, so the output comes back at the same level when the host later writes a normal-mode frame. Each commit produces a one-cycle `update` pulse. A `powered_down` flag is high while any termination mode other than normal is active.

Top module: `dacfe_top`

## Requirements
- R1: After a synchronous reset, `dac_code` is zero, `term_sel` is 2'b00 (normal), `powered_down` is low and `update` is low.
- R2: A frame is 24 bits sent most significant bit first. Frame bits 15..0 carry the code and bits 17..16 carry the mode. Bits 23..18 have no effect on any output. Codes 16'h0000 and 16'hFFFF are both stored exactly.
- R3: A frame commits on its 24th falling `sclk` edge while `fsync_n` is still low. The new values appear before `fsync_n` rises.
- R4: If `fsync_n` rises before the 24th fall, neither register changes and no `update` pulse occurs. The partial bits do not leak into the next frame.
- R5: Falling `sclk` edges while `fsync_n` is high are ignored.
- R6: After a commit, further `sclk` falls with `fsync_n` still low are ignored. No further frame is accepted until `fsync_n` rises and falls again.
- R7: `term_sel` takes the committed mode bits: 00 normal, 01 1 kOhm pulldown, 10 100 kOhm pulldown, 11 open. `powered_down` is high exactly when the mode is not 00.
- R8: A frame whose mode is not 00 leaves `dac_code` unchanged, whatever its code field holds. A later normal-mode frame loads its own code.
- R9: `update` is high for exactly one clock per committed frame, in the same cycle the new register values first appear.
- R10: Outputs change SYNC_STAGES+1 system clocks after the 24th `sclk` fall is presented at the pins (3 clocks with the default of 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| fsync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Committed output code |
| term_sel | output | 2 | Committed output-termination mode |
| powered_down | output | 1 | High while a non-normal mode is active |
| update | output | 1 | One-cycle pulse per committed frame |

## Verification
The assertions assume that every pin level is held for several system clocks. Under that assumption each `sclk` fall is seen as exactly one event, and two commits can never fall in neighbouring cycles. They also assume that `sdin` has settled well before the `sclk` fall that samples it. The stimulus holds every serial clock phase for four system clocks and changes `sdin` only on the rising half. It moves `fsync_n` only while `sclk` is low and steady. Aborted, overlong and back-to-back frames are all built from these same slow phases.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int DAC_CODE_W = 16;
    localparam int FRAME_LEN  = 24;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'b00,
        PM_PD_1K   = 2'b01,
        PM_PD_100K = 2'b10,
        PM_PD_OPEN = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_HOLD
    } frame_st_e;

    typedef struct packed {
        logic sclk_fall;
        logic fs_fall;
        logic fs_high;
        logic din;
    } pin_ev_t;

    function automatic logic mode_is_off(pmode_e m);
        return m != PM_ACTIVE;
    endfunction

endpackage

// File: rtl/dacfe_pin_sync.sv
module dacfe_pin_sync
    import dacfe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_i,
    input  logic    fs_n_i,
    input  logic    din_i,
    output pin_ev_t ev_o
);
    localparam int NPIN = 3;
    // bit order {din, fs_n, sclk}; idle levels: select high, clock low
    localparam logic [NPIN-1:0] IDLE_LVL = 3'b010;

    logic [NPIN-1:0]              raw;
    logic [STAGES-1:0][NPIN-1:0]  chain;
    logic [NPIN-1:0]              cur;
    logic [NPIN-1:0]              prev_q;

    assign raw = {din_i, fs_n_i, sclk_i};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= IDLE_LVL;
                else     chain[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= IDLE_LVL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign cur = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LVL;
        else     prev_q <= cur;
    end

    always_comb begin
        ev_o.sclk_fall = prev_q[0] & ~cur[0];
        ev_o.fs_fall   = prev_q[1] & ~cur[1];
        ev_o.fs_high   = cur[1];
        ev_o.din       = cur[2];
    end
endmodule

// File: rtl/dacfe_frame_shift.sv
module dacfe_frame_shift
    import dacfe_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_LEN,
    parameter int KEEP_W     = DAC_CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    output logic              commit_o,
    output logic [KEEP_W-1:0] word_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    frame_st_e           st;
    logic [CNT_W-1:0]    cnt;
    logic [KEEP_W-2:0]   shreg;   // only the tail that carries mode and code
    logic                take_bit;

    always_comb begin
        take_bit = (st == FR_SHIFT) && !ev.fs_high && ev.sclk_fall;
        word_o   = {shreg, ev.din};
        commit_o = take_bit && (cnt == CNT_W'(FRAME_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FR_IDLE;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            unique case (st)
                FR_IDLE: begin
                    if (ev.fs_fall) begin
                        st    <= FR_SHIFT;
                        cnt   <= '0;
                        shreg <= '0;
                    end
                end
                FR_SHIFT: begin
                    if (ev.fs_high) begin
                        st    <= FR_IDLE;
                        cnt   <= '0;
                        shreg <= '0;
                    end else if (take_bit) begin
                        shreg <= word_o[KEEP_W-2:0];
                        if (commit_o) begin
                            st  <= FR_HOLD;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                FR_HOLD: begin
                    if (ev.fs_high) st <= FR_IDLE;
                end
                default: st <= FR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
    import dacfe_pkg::*;
#(
    parameter int CODE_W = DAC_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [CODE_W+1:0] word,
    output logic [CODE_W-1:0] code_q,
    output pmode_e            mode_q,
    output logic              upd_q
);
    pmode_e            new_mode;
    logic [CODE_W-1:0] new_code;

    assign new_mode = pmode_e'(word[CODE_W+1:CODE_W]);
    assign new_code = word[CODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mode_q <= PM_ACTIVE;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= commit;
            if (commit) begin
                mode_q <= new_mode;
                if (!mode_is_off(new_mode)) code_q <= new_code;
            end
        end
    end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int CODE_W      = DAC_CODE_W,
    parameter int FRAME_BITS  = FRAME_LEN,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              fsync_n,
    input  logic              sdin,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        term_sel,
    output logic              powered_down,
    output logic              update
);
    localparam int KEEP_W = CODE_W + 2;

    pin_ev_t           ev;
    logic              commit;
    logic [KEEP_W-1:0] word;
    pmode_e            mode_q;

    dacfe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk),
        .fs_n_i (fsync_n),
        .din_i  (sdin),
        .ev_o   (ev)
    );

    dacfe_frame_shift #(.FRAME_BITS(FRAME_BITS), .KEEP_W(KEEP_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .commit_o (commit),
        .word_o   (word)
    );

    dacfe_regs #(.CODE_W(CODE_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (word),
        .code_q (dac_code),
        .mode_q (mode_q),
        .upd_q  (update)
    );

    assign term_sel     = mode_q;
    assign powered_down = mode_is_off(mode_q);
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
    parameter int CODE_W     = 16,
    parameter int FRAME_BITS = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_sclk_fall,
    input logic              ev_fs_fall,
    input logic              ev_fs_high,
    input logic [CODE_W-1:0] dac_code,
    input logic [1:0]        term_sel,
    input logic              update
);
    localparam int CW  = $clog2(FRAME_BITS + 2);
    localparam int LIM = FRAME_BITS + 1;

    logic [CW-1:0] falls;

    // independent count of sampled clock falls inside the current selection
    always_ff @(posedge clk) begin
        if (rst || ev_fs_high || ev_fs_fall) falls <= '0;
        else if (ev_sclk_fall && falls != CW'(LIM)) falls <= falls + 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && term_sel == 2'b00 && !update));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        update |=> !update);

    a_r3_regs_hold_without_update: assert property (@(posedge clk) disable iff (rst)
        !update |-> ($stable(dac_code) && $stable(term_sel)));

    a_r8_powerdown_keeps_code: assert property (@(posedge clk) disable iff (rst)
        (update && term_sel != 2'b00) |-> $stable(dac_code));

    a_r4_commit_needs_full_frame: assert property (@(posedge clk) disable iff (rst)
        update |-> (falls == CW'(FRAME_BITS)));
endmodule

bind dacfe_top dacfe_chk #(.CODE_W(CODE_W), .FRAME_BITS(FRAME_BITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_sclk_fall (ev.sclk_fall),
    .ev_fs_fall   (ev.fs_fall),
    .ev_fs_high   (ev.fs_high),
    .dac_code     (dac_code),
    .term_sel     (term_sel),
    .update       (update)
);

// File: tb/sim_dacfe_top.sv
module sim_dacfe_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        sclk, fsync_n, sdin;
    logic [15:0] dac_code;
    logic [1:0]  term_sel;
    logic        powered_down, update;

    int tests = 0;
    int fails = 0;
    int upd_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacfe_top #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .fsync_n(fsync_n), .sdin(sdin),
        .dac_code(dac_code), .term_sel(term_sel),
        .powered_down(powered_down), .update(update)
    );

    // ---------------- behavioural reference ----------------
    logic [2:0] pipe[$];          // newest first, {din, fs_n, sclk}
    int  m_phase, m_bits, m_acc, m_code, m_mode;
    bit  m_upd;

    always @(posedge clk) begin
        if (rst) begin
            pipe.delete();
            for (int i = 0; i <= SYNC; i++) pipe.push_back(3'b010);
            m_phase = 0; m_bits = 0; m_acc = 0;
            m_code = 0; m_mode = 0; m_upd = 0;
        end else begin
            logic [2:0] cur, prv;
            cur = pipe[SYNC-1];
            prv = pipe[SYNC];
            m_upd = 0;
            case (m_phase)
                0: if (prv[1] && !cur[1]) begin m_phase = 1; m_bits = 0; m_acc = 0; end
                1: begin
                    if (cur[1]) begin
                        m_phase = 0; m_bits = 0; m_acc = 0;
                    end else if (prv[0] && !cur[0]) begin
                        m_acc = (m_acc << 1) | int'(cur[2]);
                        m_bits++;
                        if (m_bits == 24) begin
                            m_upd  = 1;
                            m_mode = (m_acc >> 16) & 3;
                            if (m_mode == 0) m_code = m_acc & 16'hFFFF;
                            m_phase = 2;
                        end
                    end
                end
                default: if (cur[1]) m_phase = 0;
            endcase
            pipe.push_front({sdin, fsync_n, sclk});
            void'(pipe.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            tests += 4;
            if (dac_code !== m_code[15:0]) begin
                fails++; $display("FAIL R2 dac_code got %h exp %h", dac_code, m_code[15:0]);
            end
            if (term_sel !== m_mode[1:0]) begin
                fails++; $display("FAIL R7 term_sel got %b exp %b", term_sel, m_mode[1:0]);
            end
            if (powered_down !== (m_mode != 0)) begin
                fails++; $display("FAIL R7 powered_down got %b exp %b", powered_down, m_mode != 0);
            end
            if (update !== m_upd) begin
                fails++; $display("FAIL R9 update got %b exp %b", update, m_upd);
            end
            if (update) upd_seen++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [23:0] w, input int n, input bit raise, input bit lat);
        @(negedge clk); fsync_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdin = w[23-i]; sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            if (lat && i == n-1) begin
                repeat (SYNC) @(negedge clk);
                chk("R10 update not yet", {31'd0, update}, 32'd0);
                @(negedge clk);
                chk("R10 update on time", {31'd0, update}, 32'd1);
                repeat (HALF-SYNC-1) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
        end
        if (raise) begin
            fsync_n = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic release_sync();
        @(negedge clk); fsync_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int base;
        rst = 1'b1; sclk = 1'b0; fsync_n = 1'b1; sdin = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code", {16'd0, dac_code}, 32'd0);
        chk("R1 mode", {30'd0, term_sel}, 32'd0);
        chk("R1 pd/update", {30'd0, powered_down, update}, 32'd0);

        // R2/R3/R10: junk in top bits, commit before select rises
        base = upd_seen;
        send({6'h3F, 2'b00, 16'hABCD}, 24, 1'b0, 1'b1);
        chk("R3 committed while selected", {16'd0, dac_code}, 32'h0000ABCD);
        chk("R2 junk bits ignored", {30'd0, term_sel}, 32'd0);
        release_sync();
        chk("R9 one pulse", upd_seen - base, 32'd1);

        // R4: abort after 20 bits, then a clean frame
        base = upd_seen;
        send({6'h00, 2'b11, 16'h1234}, 20, 1'b1, 1'b0);
        chk("R4 code after abort", {16'd0, dac_code}, 32'h0000ABCD);
        chk("R4 mode after abort", {30'd0, term_sel}, 32'd0);
        chk("R4 no pulse", upd_seen - base, 32'd0);
        send({6'h15, 2'b00, 16'h5555}, 24, 1'b1, 1'b0);
        chk("R4 no leak", {16'd0, dac_code}, 32'h00005555);

        // R5: clocks with select high
        base = upd_seen;
        sdin = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); sclk = 1'b1; repeat (HALF) @(negedge clk);
            sclk = 1'b0; repeat (HALF-1) @(negedge clk);
        end
        chk("R5 code", {16'd0, dac_code}, 32'h00005555);
        chk("R5 no pulse", upd_seen - base, 32'd0);

        // R6: extra falls and a second frame without a new select fall
        base = upd_seen;
        send({6'h00, 2'b00, 16'h0F0F}, 24, 1'b0, 1'b0);
        send({6'h00, 2'b10, 16'hDEAD}, 24, 1'b0, 1'b0);
        chk("R6 extra falls ignored", {16'd0, dac_code}, 32'h00000F0F);
        chk("R6 mode", {30'd0, term_sel}, 32'd0);
        chk("R6 one pulse", upd_seen - base, 32'd1);
        release_sync();

        // R7/R8: each power-down mode keeps the code
        for (int m = 1; m < 4; m++) begin
            send({6'h00, 2'(m), 16'h7777}, 24, 1'b1, 1'b0);
            chk("R7 term_sel", {30'd0, term_sel}, 32'(m));
            chk("R7 powered_down", {31'd0, powered_down}, 32'd1);
            chk("R8 code kept", {16'd0, dac_code}, 32'h00000F0F);
        end
        send({6'h2A, 2'b00, 16'hFFFF}, 24, 1'b1, 1'b0);
        chk("R8 normal loads code", {16'd0, dac_code}, 32'h0000FFFF);
        chk("R7 back to normal", {30'd0, term_sel, powered_down}, 32'd0);
        send({6'h3F, 2'b00, 16'h0000}, 24, 1'b1, 1'b0);
        chk("R2 zero code", {16'd0, dac_code}, 32'd0);

        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule